// File: doc/BRIEF.md
# Periodic Reload Timer with Acknowledge

This block is a down-counting timer that runs on a reference tick strobe (one `ref_tick` pulse per cycle of a 38.4 MHz reference). Software programs a single 32-bit control word. The word holds a 28-bit period, an enable bit, an interrupt-enable bit, a spare stored bit and a sticky flag. Once the programmed number of reference ticks has elapsed, the flag is raised and the next period of the same length begins at once, so the timer keeps running periodically without software help.

The interrupt output is a level signal for a downstream router. It is the AND of the flag and the interrupt enable. Software services the interrupt by writing a separate acknowledge address. A write there can clear the flag, restart the current period, or do both. The acknowledge address always reads as zero.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, `irq` is low and the timer is stopped.
- R2: A write to the control offset (0x34) replaces all 32 bits, including the flag in bit 31. The word reads back at that offset exactly as stored. Its fields are: bits [27:0] the period, bit 28 enable, bit 29 interrupt enable, bit 30 stored only, bit 31 flag.
- R3: A control write with bit 28 set and a nonzero period N loads the count. The flag becomes set after the N-th `ref_tick` cycle that follows the write cycle. A `ref_tick` that arrives in the write cycle itself is not counted.
- R4: On each expiry the flag is set and a new period of N ticks starts immediately. Expiries therefore repeat every N ticks, and this holds for any spacing of the ticks.
- R5: `irq` is high exactly when bit 31 and bit 29 of the stored word are both set.
- R6: A control write with bit 28 clear stops the countdown. No flag is raised however many ticks arrive afterwards.
- R7: A write to the acknowledge offset (0x38) with bit 31 set clears the flag. Bits other than 30 and 31 of that write have no effect.
- R8: An acknowledge write with bit 30 set restarts the full period while bit 28 is set. When bit 28 is clear, the restart request has no effect. In the cycle of a restart, a tick is not counted.
- R9: While the timer is enabled with a period of zero, the flag is never set by counting.
- R10: If an acknowledge clear and an expiry fall in the same cycle, the flag stays set. A control write takes precedence over both.
- R11: Reads at the acknowledge offset, and at any offset other than the control offset, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The countdown is tried with a tick on every cycle and with a tick only on every third cycle. Together these show whether the period is measured in reference ticks or in clock cycles. Periods of 1, 2, 4 and 6 are each used both with and without acknowledges interleaved. This separates an off-by-one in the reload from a missed restart and from a flag that is cleared too eagerly. The period-of-one case with an acknowledge on every cycle forces a clear and an expiry into the same cycle. Disabled restarts, zero periods and mid-count disables show that the count is held still rather than merely that no interrupt is routed.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  CTRL_OFS = 8'h34,
  parameter logic [7:0]  ACK_OFS  = 8'h38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          irq
);
  localparam int unsigned VW  = 28;
  localparam int unsigned EN  = VW;
  localparam int unsigned IE  = VW + 1;
  localparam int unsigned RST = VW + 2;
  localparam int unsigned FL  = 31;
  localparam logic [VW-1:0] ONE = VW'(1);

  logic [31:0]   ctrl_q;
  logic [VW-1:0] cnt_q;

  logic [VW-1:0] period;
  logic          en, ctl_wr, ack_wr, running, restart, expire;

  assign period  = ctrl_q[VW-1:0];
  assign en      = ctrl_q[EN];
  assign ctl_wr  = wr_en && (wr_addr == AW'(CTRL_OFS));
  assign ack_wr  = wr_en && (wr_addr == AW'(ACK_OFS));
  assign running = en && (period != '0);
  assign restart = ack_wr && wr_data[RST] && en;
  assign expire  = !ctl_wr && !restart && running && ref_tick && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else if (ctl_wr) begin
      ctrl_q <= wr_data;
      cnt_q  <= wr_data[VW-1:0];
    end else begin
      if (restart)
        cnt_q <= period;
      else if (running && ref_tick)
        cnt_q <= (cnt_q <= ONE) ? period : cnt_q - ONE;
      if (expire)
        ctrl_q[FL] <= 1'b1;
      else if (ack_wr && wr_data[FL])
        ctrl_q[FL] <= 1'b0;
    end
  end

  assign rd_data = (rd_addr == AW'(CTRL_OFS)) ? ctrl_q : '0;
  assign irq     = ctrl_q[FL] & ctrl_q[IE];

  p_expire_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ref_tick && cnt_q == ONE && !ctl_wr && !restart) |=> ctrl_q[FL]);

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q != '0 && cnt_q <= period));

  p_stopped_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctl_wr) |=> $stable(cnt_q));

  p_zero_period_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && !ctrl_q[FL] && !ctl_wr) |=> !ctrl_q[FL]);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && wr_data[FL] && !expire) |=> !ctrl_q[FL]);

  p_ack_loses_to_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && wr_data[FL] && expire) |=> ctrl_q[FL]);

  p_ack_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(ACK_OFS)) |-> (rd_data == '0));
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  localparam logic [7:0] CTRL = 8'h34;
  localparam logic [7:0] ACK  = 8'h38;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ref_tick = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = CTRL;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  reload_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  logic [31:0] m_word;
  int          m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 0;
      m_left = 0;
    end else if (wr_en && wr_addr == CTRL) begin
      m_word = wr_data;
      m_left = int'(wr_data & 32'h0fff_ffff);
    end else begin
      int  per;
      bit  fired;
      per   = int'(m_word & 32'h0fff_ffff);
      fired = 0;
      if (wr_en && wr_addr == ACK && wr_data[30] && m_word[28])
        m_left = per;
      else if (m_word[28] && per != 0 && ref_tick) begin
        m_left = m_left - 1;
        if (m_left <= 0) begin
          fired  = 1;
          m_left = per;
        end
      end
      if (fired) m_word[31] = 1'b1;
      else if (wr_en && wr_addr == ACK && wr_data[31]) m_word[31] = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, rd_data, (rd_addr == CTRL) ? m_word : 32'h0);
      check(phase, {31'b0, irq}, {31'b0, m_word[31] & m_word[29]});
    end
  end

  task automatic step(input logic t, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    #2;
    ref_tick = t; wr_en = w; wr_addr = a; wr_data = d;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) step((i % gap) == 0, 0, 8'h00, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    step(0, 0, 8'h00, 0);
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    ticks(10, 1);
    check("R1 stopped after reset", {31'b0, irq}, 32'h0);

    phase = "R2";
    step(1, 1, CTRL, 32'hC000_0005);
    step(0, 0, 8'h00, 0);
    check("R2 full-word readback", rd_data, 32'hC000_0005);
    check("R5 flag without enable", {31'b0, irq}, 32'h0);
    phase = "R5";
    step(0, 1, CTRL, 32'hA000_0000);
    step(0, 0, 8'h00, 0);
    check("R5 flag and enable", {31'b0, irq}, 32'h1);

    phase = "R3";
    step(1, 1, CTRL, 32'h3000_0004);
    step(1, 0, 8'h00, 0);
    step(1, 0, 8'h00, 0);
    step(1, 0, 8'h00, 0);
    step(1, 0, 8'h00, 0);
    check("R3 no flag before 4th tick", {31'b0, irq}, 32'h0);
    step(0, 0, 8'h00, 0);
    check("R3 flag after 4th tick", {31'b0, irq}, 32'h1);
    phase = "R7";
    step(0, 1, ACK, 32'h8000_0000);
    step(0, 0, 8'h00, 0);
    check("R7 ack clears flag", {31'b0, irq}, 32'h0);
    step(0, 1, ACK, 32'h0FFF_FFFF);
    step(0, 0, 8'h00, 0);
    check("R7 other ack bits inert", rd_data, 32'h3000_0004);

    phase = "R4";
    for (int k = 0; k < 6; k++) begin
      ticks(4, 1);
      step(0, 1, ACK, 32'h8000_0000);
    end
    step(1, 1, CTRL, 32'h3000_0002);
    ticks(30, 3);
    step(0, 1, ACK, 32'h8000_0000);
    ticks(12, 3);

    phase = "R8";
    step(0, 1, CTRL, 32'h3000_0006);
    ticks(4, 1);
    step(1, 1, ACK, 32'h4000_0000);
    ticks(5, 1);
    step(0, 0, 8'h00, 0);
    check("R8 restart delays expiry", {31'b0, irq}, 32'h0);
    step(1, 0, 8'h00, 0);
    step(0, 0, 8'h00, 0);
    check("R8 expiry after full period", {31'b0, irq}, 32'h1);
    step(0, 1, CTRL, 32'h2000_0006);
    step(0, 1, ACK, 32'h4000_0000);
    ticks(12, 1);
    check("R8 restart ignored when disabled", {31'b0, irq}, 32'h0);

    phase = "R6";
    step(0, 1, CTRL, 32'h3000_0003);
    ticks(2, 1);
    step(0, 1, CTRL, 32'h2000_0003);
    ticks(20, 1);
    check("R6 disabled never flags", {31'b0, irq}, 32'h0);

    phase = "R9";
    step(0, 1, CTRL, 32'h3000_0000);
    ticks(25, 1);
    check("R9 zero period never flags", {31'b0, irq}, 32'h0);

    phase = "R10";
    step(0, 1, CTRL, 32'h3000_0001);
    step(1, 0, 8'h00, 0);
    for (int k = 0; k < 5; k++) step(1, 1, ACK, 32'h8000_0000);
    step(0, 0, 8'h00, 0);
    check("R10 expiry beats ack clear", {31'b0, irq}, 32'h1);
    step(1, 1, CTRL, 32'h3000_0001);
    step(0, 0, 8'h00, 0);
    check("R10 control write beats expiry", {31'b0, irq}, 32'h0);

    phase = "R11";
    step(0, 0, 8'h00, 0);
    rd_addr = ACK;
    step(0, 0, 8'h00, 0);
    check("R11 ack offset reads zero", rd_data, 32'h0);
    rd_addr = 8'h10;
    step(0, 0, 8'h00, 0);
    check("R11 other offset reads zero", rd_data, 32'h0);
    rd_addr = CTRL;
    ticks(3, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule